// File: doc/BRIEF.md
# AC Versus Crystal Frequency Checker

The block runs on a 32.768 kHz crystal clock and watches a pulse that marks each cycle of a mains-derived AC clock (already synchronised, one crystal cycle wide). It counts crystal cycles between consecutive AC pulses. It groups these periods into a measurement window of 1, 2, 5 or 10 AC cycles and decides whether the crystal and the AC clock still agree. The failure flag is sticky.

The expected number of crystal cycles per AC cycle is an input. A 2-bit criterion picks how much error is allowed. Two modes check every AC period against the expected value, with a margin of 1 or 2 crystal cycles. The other two modes check only the window's total against the expected value times the window length, with a margin of 1 or 2 crystal cycles. Period select, criterion and expected count are to be changed only while the checker is disarmed (disabled or just cleared).

Top module: `ac_xtal_checker`

## Requirements
- R1: After reset `fail` is 0 and the checker is disarmed.
- R2: Period select picks the window length in AC cycles: 00 gives 1, 01 gives 2, 10 gives 5, 11 gives 10. In whole-window modes the total is judged only on the AC pulse that closes the window, and the next window starts at that same pulse.
- R3: The first AC pulse after reset, after a clear or after `enable` rises only starts a window and is never judged, whatever the preceding gap.
- R4: Criterion 00: each AC period whose count differs from `exp_count` by more than 1 sets `fail`.
- R5: Criterion 01: each AC period whose count differs from `exp_count` by more than 2 sets `fail`.
- R6: Criterion 10: a window whose summed count differs from `exp_count` times the window length by more than 1 sets `fail`; individual periods are not judged.
- R7: Criterion 11: as R6 with an allowed total error of 2.
- R8: A violation found at an AC pulse sets `fail` in the next clock cycle, and `fail` then stays 1 until cleared.
- R9: `clear` forces `fail` to 0 in the next cycle and disarms the checker, so the next AC pulse starts a new window (R3). `clear` wins over a violation in the same cycle.
- R10: While `enable` is 0 no AC pulse can set `fail`, the checker is disarmed and `fail` keeps its value.
- R11: A period is the number of crystal cycles from one AC pulse to the next; the count saturates at 2^CNT_W, so a missing AC pulse reads as a very long period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Checker enable |
| clear | input | 1 | Clears the failure flag and disarms |
| ac_edge | input | 1 | One-cycle pulse per AC cycle |
| period_sel | input | 2 | Window length code |
| crit_sel | input | 2 | Error criterion code |
| exp_count | input | CNT_W | Expected crystal cycles per AC cycle |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The assertions check on every cycle that the flag is sticky and clears after `clear`, that it can change only after an AC pulse or a clear, and that the window position never reaches the window length. They also check that a whole-window mode never flags in the middle of a window. The bench's scenarios are needed for the numeric side: tolerance edges of exactly 1 and 2 in each criterion, window sums that pass while single periods are far off, the unjudged first pulse and the saturating period count. A behavioural model compared on every clock covers the sequences in between.

// File: rtl/ac_xtal_checker.sv
module ac_xtal_checker #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic             ac_edge,
  input  logic [1:0]       period_sel,
  input  logic [1:0]       crit_sel,
  input  logic [CNT_W-1:0] exp_count,
  output logic             fail
);
  localparam int PER_W = CNT_W + 1;
  localparam int SUM_W = CNT_W + 5;

  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       idx;
  logic [SUM_W-1:0] sum;
  logic [3:0]       win_len;
  logic [PER_W-1:0] period, exp_ext, d_cyc;
  logic [SUM_W-1:0] sum_next, exp_total, d_sum;
  logic [2:0]       tol;
  logic             judge, win_end, viol;

  always_comb begin
    case (period_sel)
      2'b00:   win_len = 4'd1;
      2'b01:   win_len = 4'd2;
      2'b10:   win_len = 4'd5;
      default: win_len = 4'd10;
    endcase
  end

  assign period    = {1'b0, cnt} + PER_W'(1);
  assign exp_ext   = {1'b0, exp_count};
  assign d_cyc     = (period > exp_ext) ? period - exp_ext : exp_ext - period;
  assign sum_next  = sum + SUM_W'(period);
  assign exp_total = SUM_W'(exp_count) * SUM_W'(win_len);
  assign d_sum     = (sum_next > exp_total) ? sum_next - exp_total : exp_total - sum_next;
  assign tol       = crit_sel[0] ? 3'd2 : 3'd1;
  assign win_end   = (idx + 4'd1) == win_len;
  assign judge     = enable && !clear && armed && ac_edge;
  assign viol      = judge && (crit_sel[1] ? (win_end && d_sum > SUM_W'(tol))
                                           : (d_cyc > PER_W'(tol)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      idx   <= '0;
      sum   <= '0;
      fail  <= 1'b0;
    end else if (clear || !enable) begin
      armed <= 1'b0;
      cnt   <= '0;
      idx   <= '0;
      sum   <= '0;
      if (clear) fail <= 1'b0;
    end else begin
      if (ac_edge) cnt <= '0;
      else if (cnt != '1) cnt <= cnt + CNT_W'(1);
      if (ac_edge) begin
        if (!armed || win_end) begin
          idx <= '0;
          sum <= '0;
        end else begin
          idx <= idx + 4'd1;
          sum <= sum_next;
        end
        armed <= 1'b1;
      end
      if (viol) fail <= 1'b1;
    end
  end

  // R8: sticky until cleared
  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !clear |=> fail);
  // R9: clear drops the flag
  p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !fail);
  // R10: no setting without an enabled AC pulse
  p_set_needs_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fail && !(ac_edge && enable) |=> !fail);
  // R2: window position stays inside the window
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> idx < win_len);
  // R6: whole-window modes judge only at the closing pulse
  p_mid_window_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    crit_sel[1] && !fail && !win_end |=> !fail);
endmodule

// File: tb/tb_ac_xtal_checker.sv
module tb_ac_xtal_checker;
  localparam int CNT_W = 12;
  localparam int SAT = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0, enable = 1'b0, clear = 1'b0, ac_edge = 1'b0;
  logic [1:0] period_sel = 2'b00, crit_sel = 2'b00;
  logic [CNT_W-1:0] exp_count = 12'd20;
  logic fail;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, last_edge = 0;
  int m_idx = 0, m_sum = 0;
  bit m_armed = 0, m_fail = 0;

  always #4 clk = ~clk;

  ac_xtal_checker #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear), .ac_edge(ac_edge),
    .period_sel(period_sel), .crit_sel(crit_sel), .exp_count(exp_count), .fail(fail));

  function automatic int absd(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic int wlen(logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 5;
      default: return 10;
    endcase
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_armed = 0; m_fail = 0; m_idx = 0; m_sum = 0;
    end else if (clear || !enable) begin
      m_armed = 0; m_idx = 0; m_sum = 0;
      if (clear) m_fail = 0;
    end else if (ac_edge) begin
      if (!m_armed) begin
        m_armed = 1; m_idx = 0; m_sum = 0;
      end else begin
        int per, tl, n;
        per = cyc - last_edge;
        if (per > SAT) per = SAT;
        tl = crit_sel[0] ? 2 : 1;
        n = wlen(period_sel);
        m_sum += per;
        m_idx++;
        if (!crit_sel[1] && absd(per, int'(exp_count)) > tl) m_fail = 1;
        if (m_idx == n) begin
          if (crit_sel[1] && absd(m_sum, int'(exp_count) * n) > tl) m_fail = 1;
          m_idx = 0; m_sum = 0;
        end
      end
      last_edge = cyc;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (fail !== m_fail) begin
        n_bad++;
        $display("FAIL R8 model compare at cycle %0d: actual %b expected %b", cyc, fail, m_fail);
      end
    end
  end

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic edge_after(int g);
    repeat (g - 1) @(negedge clk);
    ac_edge = 1'b1;
    @(negedge clk);
    ac_edge = 1'b0;
  endtask

  task automatic do_clear(logic [1:0] ps, logic [1:0] cs);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    @(negedge clk);
    period_sel = ps;
    crit_sel = cs;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset", fail, 1'b0);
    enable = 1'b1;

    // R4 criterion 00, window 1
    edge_after(5);
    check("R3 first pulse unjudged", fail, 1'b0);
    edge_after(20); edge_after(21); edge_after(19);
    check("R4 within 1", fail, 1'b0);
    edge_after(22);
    check("R4 off by 2", fail, 1'b1);
    edge_after(20);
    check("R8 sticky", fail, 1'b1);
    do_clear(2'b01, 2'b01);
    check("R9 clear", fail, 1'b0);

    // R5 criterion 01, window 2; R3 long first gap
    edge_after(300);
    check("R3 first pulse after clear", fail, 1'b0);
    edge_after(22); edge_after(18);
    check("R5 within 2", fail, 1'b0);
    edge_after(23);
    check("R5 off by 3", fail, 1'b1);

    // R9 clear beats a violation in the same cycle
    clear = 1'b1; ac_edge = 1'b1;
    @(negedge clk);
    clear = 1'b0; ac_edge = 1'b0;
    check("R9 clear priority", fail, 1'b0);
    @(negedge clk);
    period_sel = 2'b10; crit_sel = 2'b10;

    // R6 criterion 10, window 5
    edge_after(3);
    edge_after(25); edge_after(15); edge_after(20); edge_after(21); edge_after(20);
    check("R6 sum 101 vs 100", fail, 1'b0);
    edge_after(20); edge_after(20); edge_after(20); edge_after(40);
    check("R2 no judgement mid window", fail, 1'b0);
    edge_after(2);
    check("R6 sum 102 at window end", fail, 1'b1);
    do_clear(2'b11, 2'b11);

    // R7 criterion 11, window 10
    edge_after(7);
    for (int i = 0; i < 9; i++) edge_after(20);
    edge_after(22);
    check("R7 sum off by 2", fail, 1'b0);
    for (int i = 0; i < 9; i++) edge_after(20);
    check("R2 window of 10 not yet closed", fail, 1'b0);
    edge_after(23);
    check("R7 sum off by 3", fail, 1'b1);
    do_clear(2'b00, 2'b00);

    // R10 disabled
    enable = 1'b0;
    edge_after(3); edge_after(90); edge_after(4);
    check("R10 disabled no fail", fail, 1'b0);
    enable = 1'b1;
    edge_after(2);
    check("R10 re-enable first pulse unjudged", fail, 1'b0);
    edge_after(20);
    check("R10 enabled in tolerance", fail, 1'b0);

    // R11 saturation: missing AC pulses read as long period
    edge_after(5000);
    check("R11 long gap flagged", fail, 1'b1);
    enable = 1'b0;
    edge_after(3);
    check("R10 disabled keeps flag", fail, 1'b1);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule